// File: doc/BRIEF.md
# Packet Header Parser for an I2C Master

This block sits between a transmit word FIFO and a byte-level I2C master engine. Software describes each transfer in-band: three header words are pushed into the transmit FIFO, followed, for writes, by the payload packed four bytes per word. The parser pops the header and decodes the target address, direction, length, address width and the bus condition that closes the transfer. It then hands one command to the engine through a valid/ready handshake.

For a write, the parser unpacks the payload words and feeds the engine one byte at a time. For a read, it packs the bytes the engine returns into words and pushes them toward a receive FIFO. When the engine reports that the closing condition is done, the parser can raise a completion pulse.

A not-acknowledge from the engine either aborts the packet or is ignored, as the header selects. On abort, the unsent payload words are popped and dropped, so that the next word read is again a header. The SCL/SDA bit engine lies outside this block.

Top module: `pkt_hdr_parser`

## Requirements
- R1: A first header word whose protocol marker (bit 4) is clear is popped and dropped, and the next word is again treated as a first header word. Bits 31:28, 23:16 and 15:12 of that word are not interpreted.
- R2: Bits 11:0 of the second header word hold the payload length minus one. `cmd_len_o` presents that value plus one, from 1 up to 4096.
- R3: In the third header word, bit 18 selects the 10-bit address taken from bits 9:0. When bit 18 is clear, the 7-bit address from bits 7:1 is zero-extended. `cmd_ten_bit_o`, `cmd_read_o`, `cmd_hs_o` and `cmd_start_byte_o` copy bits 18, 19, 22 and 20.
- R4: `cmd_end_o` is 2 (no stop, no repeated start) when third-word bit 15 is set. It is 1 (repeated start) when bit 15 is clear and bit 16 is set, and 0 (STOP) when both bits are clear.
- R5: Each accepted packet produces exactly one command. Its fields stay stable while `cmd_valid_o` waits for `cmd_ready_i`.
- R6: Write payload bytes come out on `wr_byte_o` least significant byte first, exactly length bytes in all. The unused upper bytes of a final partial word are never sent. A byte is held until `wr_ready_i` accepts it.
- R7: Read bytes are packed least significant byte first. A word is pushed on `rxf_push_o` after every fourth byte and after the last byte, with the unused upper lanes zero.
- R8: `done_o` pulses for one cycle after `end_done_i` closes a packet, but only when third-word bit 17 is set.
- R9: With third-word bit 21 clear, `nack_i` during a transfer pulses `nack_o`, suppresses `done_o` and stops byte traffic. The remaining payload words of a write are popped and dropped, and parsing resumes at the next header.
- R10: With third-word bit 21 set, `nack_i` is ignored: no `nack_o`, and the transfer runs to completion.
- R11: After reset the parser is ready for a first header word and issues no command, byte, push or pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| txf_data_i | input | 32 | Word at the head of the transmit FIFO |
| txf_valid_i | input | 1 | Transmit FIFO not empty |
| txf_ready_o | output | 1 | Pop the head word this cycle |
| cmd_valid_o | output | 1 | Command offered to engine |
| cmd_ready_i | input | 1 | Engine accepts command |
| cmd_addr_o | output | 10 | Target address |
| cmd_ten_bit_o | output | 1 | 10-bit addressing |
| cmd_read_o | output | 1 | Read transfer |
| cmd_hs_o | output | 1 | High-speed mode request |
| cmd_start_byte_o | output | 1 | Send a start byte first |
| cmd_end_o | output | 2 | 0 STOP, 1 repeated start, 2 none |
| cmd_len_o | output | 13 | Payload length in bytes |
| wr_byte_o | output | 8 | Write payload byte |
| wr_valid_o | output | 1 | Byte offered |
| wr_ready_i | input | 1 | Engine takes byte |
| rd_byte_i | input | 8 | Byte read from the bus |
| rd_valid_i | input | 1 | Read byte valid |
| rxf_data_o | output | 32 | Packed receive word |
| rxf_push_o | output | 1 | Push receive word |
| nack_i | input | 1 | Engine saw no acknowledge |
| end_done_i | input | 1 | Engine finished the closing condition |
| done_o | output | 1 | Packet complete pulse |
| nack_o | output | 1 | Abort-on-NACK pulse |

## Verification
The assertions take for granted several things about the engine. It raises `nack_i` only while a packet is in its byte or closing phase. It raises `end_done_i` only after the last byte has moved. It never drops `rd_valid_i` into a cycle without a read in progress. The engine model in the stimulus counts the bytes of each command and raises the closing signal only when that count reaches zero. It holds `wr_ready_i` low in any cycle where it reports a NACK, so that an acceptance and an abort never coincide.

// File: rtl/pkt_hdr_pkg.sv
package pkt_hdr_pkg;
  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 10;

  localparam int H0_PROTO   = 4;
  localparam int H2_HS      = 22;
  localparam int H2_NCONT   = 21;
  localparam int H2_SBYTE   = 20;
  localparam int H2_READ    = 19;
  localparam int H2_TEN     = 18;
  localparam int H2_IE      = 17;
  localparam int H2_RSTART  = 16;
  localparam int H2_NOEND   = 15;

  typedef enum logic [1:0] {
    END_STOP   = 2'd0,
    END_RSTART = 2'd1,
    END_NONE   = 2'd2
  } end_e;

  typedef enum logic [2:0] {
    ST_H0, ST_H1, ST_H2, ST_CMD, ST_WR, ST_RD, ST_FIN, ST_DRAIN
  } st_e;
endpackage

// File: rtl/pkt_tx_unpack.sv
module pkt_tx_unpack #(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              take_i,
  input  logic              drop_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              have_o
);
  localparam int LANES = WORD_W / BYTE_W;
  localparam int IDX_W = $clog2(LANES);

  logic [WORD_W-1:0] word_q;
  logic [IDX_W-1:0]  idx_q;
  logic [BYTE_W-1:0] lane [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = word_q[g*BYTE_W +: BYTE_W];
  end

  assign byte_o = lane[idx_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      idx_q  <= '0;
      have_o <= 1'b0;
    end else if (drop_i) begin
      have_o <= 1'b0;
    end else if (load_i) begin
      word_q <= word_i;
      idx_q  <= '0;
      have_o <= 1'b1;
    end else if (take_i) begin
      idx_q <= idx_q + 1'b1;
      if (idx_q == IDX_W'(LANES-1)) have_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pkt_rx_pack.sv
module pkt_rx_pack #(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              valid_i,
  input  logic              last_i,
  input  logic              clear_i,
  output logic [WORD_W-1:0] word_o,
  output logic              push_o
);
  localparam int LANES = WORD_W / BYTE_W;
  localparam int IDX_W = $clog2(LANES);

  logic [WORD_W-1:0] acc_q, acc_nxt;
  logic [IDX_W-1:0]  idx_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign acc_nxt[g*BYTE_W +: BYTE_W] =
      (valid_i && idx_q == IDX_W'(g)) ? byte_i : acc_q[g*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      idx_q  <= '0;
      word_o <= '0;
      push_o <= 1'b0;
    end else begin
      push_o <= 1'b0;
      if (clear_i) begin
        acc_q <= '0;
        idx_q <= '0;
      end else if (valid_i) begin
        if (last_i || idx_q == IDX_W'(LANES-1)) begin
          word_o <= acc_nxt;
          push_o <= 1'b1;
          acc_q  <= '0;
          idx_q  <= '0;
        end else begin
          acc_q <= acc_nxt;
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pkt_hdr_parser.sv
module pkt_hdr_parser
  import pkt_hdr_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       txf_data_i,
  input  logic              txf_valid_i,
  output logic              txf_ready_o,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [9:0]        cmd_addr_o,
  output logic              cmd_ten_bit_o,
  output logic              cmd_read_o,
  output logic              cmd_hs_o,
  output logic              cmd_start_byte_o,
  output logic [1:0]        cmd_end_o,
  output logic [LEN_W:0]    cmd_len_o,
  output logic [7:0]        wr_byte_o,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  input  logic [7:0]        rd_byte_i,
  input  logic              rd_valid_i,
  output logic [31:0]       rxf_data_o,
  output logic              rxf_push_o,
  input  logic              nack_i,
  input  logic              end_done_i,
  output logic              done_o,
  output logic              nack_o
);
  localparam int CNT_W  = LEN_W + 1;
  localparam int WCNT_W = LEN_W - 1;

  st_e               st_q;
  logic [LEN_W-1:0]  len_m1_q;
  logic [CNT_W-1:0]  rem_q;
  logic [WCNT_W-1:0] wleft_q, wl_after;
  logic [ADDR_W-1:0] addr_q;
  end_e              end_q;
  logic read_q, ten_q, hs_q, sbyte_q, ie_q, ncont_q;
  logic pop, wr_fire, rd_take, last_byte, abort, have;
  logic unused_hdr;

  assign unused_hdr = ^{txf_data_i[31:23], txf_data_i[14:12]};

  assign txf_ready_o = (st_q == ST_H0) || (st_q == ST_H1) || (st_q == ST_H2) ||
                       (st_q == ST_DRAIN) || (st_q == ST_WR && !have);
  assign pop       = txf_valid_i && txf_ready_o;
  assign wr_valid_o = (st_q == ST_WR) && have;
  assign wr_fire   = wr_valid_o && wr_ready_i;
  assign rd_take   = (st_q == ST_RD) && rd_valid_i;
  assign last_byte = (rem_q == CNT_W'(1));
  assign abort     = nack_i && !ncont_q &&
                     (st_q == ST_WR || st_q == ST_RD || st_q == ST_FIN);
  assign wl_after  = wleft_q - WCNT_W'(pop);

  assign cmd_valid_o      = (st_q == ST_CMD);
  assign cmd_addr_o       = addr_q;
  assign cmd_ten_bit_o    = ten_q;
  assign cmd_read_o       = read_q;
  assign cmd_hs_o         = hs_q;
  assign cmd_start_byte_o = sbyte_q;
  assign cmd_end_o        = end_q;
  assign cmd_len_o        = CNT_W'(len_m1_q) + CNT_W'(1);

  pkt_tx_unpack #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_unpack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (pop && st_q == ST_WR),
    .word_i (txf_data_i),
    .take_i (wr_fire),
    .drop_i ((wr_fire && last_byte) || abort),
    .byte_o (wr_byte_o),
    .have_o (have)
  );

  pkt_rx_pack #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_pack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .byte_i  (rd_byte_i),
    .valid_i (rd_take && !abort),
    .last_i  (last_byte),
    .clear_i (abort && st_q == ST_RD),
    .word_o  (rxf_data_o),
    .push_o  (rxf_push_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_H0;
      len_m1_q <= '0;
      rem_q    <= '0;
      wleft_q  <= '0;
      addr_q   <= '0;
      end_q    <= END_STOP;
      read_q   <= 1'b0;
      ten_q    <= 1'b0;
      hs_q     <= 1'b0;
      sbyte_q  <= 1'b0;
      ie_q     <= 1'b0;
      ncont_q  <= 1'b0;
      done_o   <= 1'b0;
      nack_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      nack_o <= abort;
      if (pop && (st_q == ST_WR || st_q == ST_DRAIN)) wleft_q <= wl_after;
      unique case (st_q)
        ST_H0: if (pop && txf_data_i[H0_PROTO]) st_q <= ST_H1;
        ST_H1: if (pop) begin
          len_m1_q <= txf_data_i[LEN_W-1:0];
          st_q     <= ST_H2;
        end
        ST_H2: if (pop) begin
          ten_q   <= txf_data_i[H2_TEN];
          read_q  <= txf_data_i[H2_READ];
          hs_q    <= txf_data_i[H2_HS];
          sbyte_q <= txf_data_i[H2_SBYTE];
          ie_q    <= txf_data_i[H2_IE];
          ncont_q <= txf_data_i[H2_NCONT];
          addr_q  <= txf_data_i[H2_TEN] ? txf_data_i[ADDR_W-1:0]
                                        : {3'b000, txf_data_i[7:1]};
          // no-end beats repeated start
          end_q   <= txf_data_i[H2_NOEND]  ? END_NONE   :
                     txf_data_i[H2_RSTART] ? END_RSTART : END_STOP;
          st_q    <= ST_CMD;
        end
        ST_CMD: if (cmd_ready_i) begin
          rem_q   <= cmd_len_o;
          wleft_q <= read_q ? '0 : WCNT_W'(len_m1_q >> 2) + WCNT_W'(1);
          st_q    <= read_q ? ST_RD : ST_WR;
        end
        ST_WR: begin
          if (wr_fire) rem_q <= rem_q - 1'b1;
          if (abort)                     st_q <= (wl_after == '0) ? ST_H0 : ST_DRAIN;
          else if (wr_fire && last_byte) st_q <= ST_FIN;
        end
        ST_RD: begin
          if (abort) st_q <= ST_H0;
          else if (rd_take) begin
            rem_q <= rem_q - 1'b1;
            if (last_byte) st_q <= ST_FIN;
          end
        end
        ST_FIN: begin
          if (abort) st_q <= ST_H0;
          else if (end_done_i) begin
            done_o <= ie_q;
            st_q   <= ST_H0;
          end
        end
        ST_DRAIN: if (pop && wleft_q == WCNT_W'(1)) st_q <= ST_H0;
        default: st_q <= ST_H0;
      endcase
    end
  end
endmodule

// File: rtl/pkt_hdr_parser_chk.sv
module pkt_hdr_parser_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        txf_ready_o,
  input logic        cmd_valid_o,
  input logic        cmd_ready_i,
  input logic [9:0]  cmd_addr_o,
  input logic        cmd_read_o,
  input logic [1:0]  cmd_end_o,
  input logic [12:0] cmd_len_o,
  input logic [7:0]  wr_byte_o,
  input logic        wr_valid_o,
  input logic        wr_ready_i,
  input logic        rd_valid_i,
  input logic        rxf_push_o,
  input logic        nack_i,
  input logic        end_done_i,
  input logic        done_o,
  input logic        nack_o
);
  a_r5_cmd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_addr_o) &&
      $stable(cmd_len_o) && $stable(cmd_end_o) && $stable(cmd_read_o));

  a_r5_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_valid_o && wr_valid_o));

  a_r6_byte_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && !wr_ready_i && !nack_i |=> wr_valid_o && $stable(wr_byte_o));

  a_r6_no_pop_holding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> !txf_ready_o);

  a_r7_push_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxf_push_o |-> $past(rd_valid_i));

  a_r8_done_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(end_done_i));

  a_r9_nack_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nack_o |-> $past(nack_i));

  a_r9_excl_events: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && nack_o));
endmodule

bind pkt_hdr_parser pkt_hdr_parser_chk u_chk (.*);

// File: tb/pkt_hdr_parser_tb.sv
module pkt_hdr_parser_tb;
  timeunit 1ns;
  timeprecision 1ps;

  typedef struct packed {
    logic       rd;
    logic       ten;
    logic [1:0] endsel;
    logic       ie;
    logic [9:0] addr;
    logic [11:0] lenm1;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 1'b0, 2'd0, 1'b1, 10'h050, 12'd0},
    '{1'b0, 1'b0, 2'd1, 1'b1, 10'h02A, 12'd5},
    '{1'b1, 1'b0, 2'd2, 1'b1, 10'h011, 12'd4},
    '{1'b1, 1'b1, 2'd0, 1'b0, 10'h2F3, 12'd7},
    '{1'b0, 1'b1, 2'd3, 1'b1, 10'h155, 12'd3},
    '{1'b0, 1'b0, 2'd0, 1'b1, 10'h07F, 12'd8}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] txf_data, rxf_data;
  logic txf_valid, txf_ready, cmd_valid, cmd_ready, cmd_ten, cmd_read, cmd_hs, cmd_sb;
  logic [9:0] cmd_addr;
  logic [1:0] cmd_end;
  logic [12:0] cmd_len;
  logic [7:0] wr_byte, rd_byte;
  logic wr_valid, wr_ready, rd_valid, rxf_push, nack_in, end_done, done, nack_out;

  pkt_hdr_parser u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .txf_data_i(txf_data), .txf_valid_i(txf_valid), .txf_ready_o(txf_ready),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_addr_o(cmd_addr),
    .cmd_ten_bit_o(cmd_ten), .cmd_read_o(cmd_read), .cmd_hs_o(cmd_hs),
    .cmd_start_byte_o(cmd_sb), .cmd_end_o(cmd_end), .cmd_len_o(cmd_len),
    .wr_byte_o(wr_byte), .wr_valid_o(wr_valid), .wr_ready_i(wr_ready),
    .rd_byte_i(rd_byte), .rd_valid_i(rd_valid),
    .rxf_data_o(rxf_data), .rxf_push_o(rxf_push),
    .nack_i(nack_in), .end_done_i(end_done), .done_o(done), .nack_o(nack_out)
  );

  // transmit FIFO model
  logic [31:0] fmem [4096];
  int fwp = 0;
  int frp = 0;
  assign txf_valid = (frp != fwp);
  assign txf_data  = fmem[frp % 4096];
  always @(posedge clk) if (txf_valid && txf_ready) frp <= frp + 1;

  // engine model; stimulus knobs written only by the main process
  logic stall_en = 1'b0;
  logic stop_on_nack = 1'b1;
  logic [9:0] nack_addr = 10'h3FF;
  int nack_pos = 0;
  logic [7:0] rd_base = 8'h00;

  logic eng_busy = 1'b0, eng_read = 1'b0, armed = 1'b0;
  int eng_cnt = 0, eng_taken = 0, eng_served = 0, cyc = 0;
  logic nack_now;

  assign nack_now  = eng_busy && !eng_read && armed && (eng_taken == nack_pos);
  assign wr_ready  = eng_busy && !eng_read && eng_cnt != 0 && !nack_now && (!stall_en || cyc[0]);
  assign rd_valid  = eng_busy && eng_read && eng_cnt != 0 && (!stall_en || cyc[0]);
  assign rd_byte   = rd_base + eng_served[7:0];
  assign end_done  = eng_busy && eng_cnt == 0;
  assign cmd_ready = !eng_busy && (!stall_en || cyc[0]);
  assign nack_in   = nack_now;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cmd_valid && cmd_ready) begin
      eng_busy <= 1'b1; eng_read <= cmd_read; eng_cnt <= int'(cmd_len);
      eng_taken <= 0; eng_served <= 0; armed <= (cmd_addr == nack_addr);
    end else if (eng_busy) begin
      if (nack_now) begin
        armed <= 1'b0;
        if (stop_on_nack) eng_busy <= 1'b0;
      end else if (wr_valid && wr_ready) begin
        eng_cnt <= eng_cnt - 1; eng_taken <= eng_taken + 1;
      end else if (rd_valid) begin
        eng_cnt <= eng_cnt - 1; eng_served <= eng_served + 1;
      end else if (eng_cnt == 0) eng_busy <= 1'b0;
    end
  end

  // monitors, sampled mid-cycle
  logic [7:0] wlog [8192];
  logic [31:0] rlog [256];
  int nwr = 0, nrx = 0, ncmd = 0, ndone = 0, nnack = 0;
  logic [9:0] cap_addr;
  logic [12:0] cap_len;
  logic [1:0] cap_end;
  logic cap_ten, cap_read, cap_hs, cap_sb;

  always @(negedge clk) begin
    if (cmd_valid && cmd_ready) begin
      cap_addr <= cmd_addr; cap_len <= cmd_len; cap_end <= cmd_end;
      cap_ten <= cmd_ten; cap_read <= cmd_read; cap_hs <= cmd_hs; cap_sb <= cmd_sb;
      ncmd <= ncmd + 1;
    end
    if (wr_valid && wr_ready) begin wlog[nwr % 8192] <= wr_byte; nwr <= nwr + 1; end
    if (rxf_push) begin rlog[nrx % 256] <= rxf_data; nrx <= nrx + 1; end
    if (done) ndone <= ndone + 1;
    if (nack_out) nnack <= nnack + 1;
  end

  int nchk = 0, nfail = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pb(input logic [7:0] seed, input int k);
    return seed + 8'(k * 37);
  endfunction

  function automatic logic [31:0] mk_h2(input logic rd, input logic ten, input logic [9:0] addr,
      input logic ie, input logic [1:0] endsel, input logic ncont, input logic hs, input logic sb);
    logic [31:0] h;
    h = ten ? {22'd0, addr} : {22'd0, addr[6:0], 1'b0};
    h[22] = hs; h[21] = ncont; h[20] = sb; h[19] = rd; h[18] = ten;
    h[17] = ie; h[16] = endsel[0]; h[15] = endsel[1];
    return h;
  endfunction

  task automatic push(input logic [31:0] w);
    fmem[fwp % 4096] = w;
    fwp = fwp + 1;
  endtask

  task automatic push_hdr(input int len, input logic [31:0] h2);
    push(32'h3005_5010);
    push(32'(len - 1));
    push(h2);
  endtask

  task automatic push_pay(input int len, input logic [7:0] seed);
    for (int j = 0; j < (len + 3) / 4; j++) begin
      logic [31:0] w;
      w = 32'hEEEE_EEEE;
      for (int l = 0; l < 4; l++)
        if (4*j + l < len) w[8*l +: 8] = pb(seed, 4*j + l);
      push(w);
    end
  endtask

  task automatic wait_idle();
    int q = 0;
    while (q < 8) begin
      @(negedge clk);
      if (frp == fwp && !eng_busy && !cmd_valid && !wr_valid) q++;
      else q = 0;
    end
  endtask

  task automatic chk_bytes(input string tag, input int base, input int len, input logic [7:0] seed);
    int bad = 0;
    int first = -1;
    for (int k = 0; k < len; k++)
      if (wlog[(base + k) % 8192] !== pb(seed, k)) begin
        bad++;
        if (first < 0) first = k;
      end
    chk(bad == 0, tag, $sformatf("payload byte mismatches (first at %0d)", first), bad, 0);
  endtask

  task automatic run_all();
    int b_cmd, b_wr, b_rx, b_done, b_nack;
    // R11 reset state
    repeat (3) @(negedge clk);
    chk(txf_ready === 1'b1, "R11", "txf_ready in reset", txf_ready, 1);
    chk(cmd_valid === 1'b0 && wr_valid === 1'b0, "R11", "cmd/wr valid in reset",
        {cmd_valid, wr_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(txf_ready === 1'b1 && cmd_valid === 1'b0 && rxf_push === 1'b0, "R11",
        "idle after reset", {txf_ready, cmd_valid, rxf_push}, 3'b100);
    chk(done === 1'b0 && nack_out === 1'b0, "R11", "no pulses after reset", {done, nack_out}, 0);

    // table of vectors
    for (int i = 0; i < 6; i++) begin
      vec_t v;
      int len;
      logic [7:0] seed;
      logic [1:0] exp_end;
      v = VECS[i];
      len = int'(v.lenm1) + 1;
      seed = 8'(8'h11 * (i + 1));
      stall_en = i[0];
      rd_base = 8'(8'h40 + i * 16);
      b_cmd = ncmd; b_wr = nwr; b_rx = nrx; b_done = ndone;
      push_hdr(len, mk_h2(v.rd, v.ten, v.addr, v.ie, v.endsel, 1'b0, i == 3, i == 1));
      if (!v.rd) push_pay(len, seed);
      wait_idle();
      exp_end = (v.endsel[1]) ? 2'd2 : (v.endsel[0] ? 2'd1 : 2'd0);
      chk(ncmd - b_cmd == 1, "R5", $sformatf("vec %0d command count", i), ncmd - b_cmd, 1);
      chk(cap_len == 13'(len), "R2", $sformatf("vec %0d length", i), cap_len, len);
      chk(cap_addr == v.addr && cap_ten == v.ten && cap_read == v.rd, "R3",
          $sformatf("vec %0d addr/ten/read", i), {cap_read, cap_ten, cap_addr}, {v.rd, v.ten, v.addr});
      chk(cap_hs == (i == 3) && cap_sb == (i == 1), "R3", $sformatf("vec %0d hs/start byte", i),
          {cap_hs, cap_sb}, {i == 3, i == 1});
      chk(cap_end == exp_end, "R4", $sformatf("vec %0d end select", i), cap_end, exp_end);
      if (!v.rd) begin
        chk(nwr - b_wr == len, "R6", $sformatf("vec %0d byte count", i), nwr - b_wr, len);
        chk_bytes("R6", b_wr, len, seed);
      end else begin
        int bad = 0;
        chk(nrx - b_rx == (len + 3) / 4, "R7", $sformatf("vec %0d rx word count", i),
            nrx - b_rx, (len + 3) / 4);
        for (int j = 0; j < (len + 3) / 4; j++) begin
          logic [31:0] e;
          e = '0;
          for (int l = 0; l < 4; l++)
            if (4*j + l < len) e[8*l +: 8] = rd_base + 8'(4*j + l);
          if (rlog[(b_rx + j) % 256] !== e) bad++;
        end
        chk(bad == 0, "R7", $sformatf("vec %0d rx word mismatches", i), bad, 0);
      end
      chk(ndone - b_done == int'(v.ie), "R8", $sformatf("vec %0d done pulses", i),
          ndone - b_done, v.ie);
    end
    stall_en = 1'b0;

    // R1: junk header word dropped
    b_cmd = ncmd; b_wr = nwr;
    push(32'hFFFF_FFEF);
    push_hdr(2, mk_h2(1'b0, 1'b0, 10'h033, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0));
    push_pay(2, 8'h5A);
    wait_idle();
    chk(ncmd - b_cmd == 1 && cap_addr == 10'h033, "R1", "one command after junk word",
        ncmd - b_cmd, 1);
    chk(cap_len == 13'd2, "R1", "length after junk word", cap_len, 2);
    chk_bytes("R1", b_wr, 2, 8'h5A);

    // R9: abort on NACK, remaining words drained, next packet aligned
    b_cmd = ncmd; b_wr = nwr; b_done = ndone; b_nack = nnack;
    nack_addr = 10'h044; nack_pos = 2; stop_on_nack = 1'b1;
    push_hdr(10, mk_h2(1'b0, 1'b0, 10'h044, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0));
    push_pay(10, 8'h21);
    push_hdr(1, mk_h2(1'b0, 1'b0, 10'h012, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0));
    push_pay(1, 8'hA5);
    wait_idle();
    chk(nnack - b_nack == 1, "R9", "nack pulses", nnack - b_nack, 1);
    chk(ndone - b_done == 1, "R9", "done only for following packet", ndone - b_done, 1);
    chk(nwr - b_wr == 3, "R9", "bytes sent across abort", nwr - b_wr, 3);
    chk(ncmd - b_cmd == 2 && cap_addr == 10'h012, "R9", "following header aligned",
        cap_addr, 10'h012);
    chk_bytes("R9", b_wr, 2, 8'h21);
    chk(wlog[(b_wr + 2) % 8192] == pb(8'hA5, 0), "R9", "following packet byte",
        wlog[(b_wr + 2) % 8192], pb(8'hA5, 0));
    chk(frp == fwp, "R9", "payload words drained", fwp - frp, 0);

    // R10: NACK ignored when continue-on-NACK set
    b_wr = nwr; b_done = ndone; b_nack = nnack;
    nack_addr = 10'h021; nack_pos = 1; stop_on_nack = 1'b0;
    push_hdr(3, mk_h2(1'b0, 1'b0, 10'h021, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0));
    push_pay(3, 8'h77);
    wait_idle();
    chk(nnack - b_nack == 0, "R10", "no nack pulse", nnack - b_nack, 0);
    chk(nwr - b_wr == 3, "R10", "all bytes sent", nwr - b_wr, 3);
    chk_bytes("R10", b_wr, 3, 8'h77);
    chk(ndone - b_done == 1, "R10", "done pulse", ndone - b_done, 1);
    nack_addr = 10'h3FF; stop_on_nack = 1'b1;

    // R2: maximum length
    b_wr = nwr; b_done = ndone;
    push_hdr(4096, mk_h2(1'b0, 1'b0, 10'h001, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0));
    push_pay(4096, 8'h03);
    wait_idle();
    chk(cap_len == 13'd4096, "R2", "maximum length", cap_len, 4096);
    chk(nwr - b_wr == 4096, "R6", "maximum length byte count", nwr - b_wr, 4096);
    chk_bytes("R6", b_wr, 4096, 8'h03);
    chk(ndone - b_done == 1, "R8", "maximum length done", ndone - b_done, 1);
  endtask

  initial begin
    bit wd;
    wd = 1'b0;
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    disable fork;
    if (wd) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog expired actual=1 expected=0");
    end
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule